// File: doc/BRIEF.md
# Serial ADC Control-Word Front End

This block is the digital serial port of a multi-channel sampling converter. A host opens a frame by pulling an active-low chip select, then supplies 16 serial clocks. On each falling clock edge the block samples one configuration bit from the data input. In the same frame it shifts out the result of the previous conversion: a 4-bit channel tag first, then the 12-bit result, most significant bit first. The first 13 bits form a configuration word. Its leading bit decides whether the other 12 bits are stored. The channel selection in the stored word goes to the input multiplexer on the 14th falling edge. The result that the next frame reads out is captured on the 16th falling edge.

The analog conversion is modelled by a 12-bit `sample` input. A stored coding bit chooses between straight binary and two's complement for that result. A stored line-mode bit decides what the output does between transfers. It either drives the top bit of the selected channel address weakly, or it releases the line to high impedance. In this block the weak drive is a flag next to an output enable. The sequencing, power and shadow fields are kept in the stored word and have no effect here.

All serial inputs are resampled by the system clock `clk`. Every action therefore happens a few system cycles after the serial edge that triggers it.

Top module: `adc_serial_fe`

## Requirements
- R1: After a synchronous reset, `cfg_q`, `mux_addr`, `mux_single`, `dout`, `dout_oe` and `dout_weak` are all 0.
- R2: `din` is taken on falling `sclk` edges while `cs_n` is low, first bit first. Only falling edges 1 to 13 of a frame contribute to the word. The level of `din` at edges 14, 15 and 16 has no effect on any output.
- R3: When word bit 12 (the first bit sent) is 1, bits 11:0 are written to `cfg_q` on the 13th falling edge. When it is 0, `cfg_q` keeps its value. Field positions in `cfg_q`:
  - bit 11: sequencing
  - bits 10:7: channel address
  - bits 6:5: power mode
  - bit 4: shadow
  - bit 3: line mode
  - bit 2: range
  - bit 1: coding
  - bit 0: single-ended
- R4: If `cs_n` rises before the 13th falling edge, the partial word is dropped and `cfg_q` is unchanged.
- R5: On the 14th falling edge, `mux_addr` takes `cfg_q[10:7]` and `mux_single` takes `cfg_q[0]`. Neither output changes at any other time.
- R6: In a frame, `dout` presents a 16-bit word MSB first. The first bit appears when `cs_n` falls, and the next bit appears after each of falling edges 1 to 15. While bits are shifting, `dout_oe` is 1 and `dout_weak` is 0.
- R7: The 16-bit word is the 4-bit channel tag followed by the 12-bit result. The tag is `mux_addr` and the result is `sample`, both taken at the 16th falling edge of the preceding complete frame. A frame cut short before its 16th edge captures nothing.
- R8: When `cfg_q[1]` is 1 at capture, the result is `sample` unchanged. When it is 0, the result is `sample` with its MSB inverted (two's complement of an offset-binary value).
- R9: After the 16th falling edge, or while `cs_n` is high, the output depends on `cfg_q[3]`:
  - `cfg_q[3]` = 1: `dout_oe` = 1, `dout_weak` = 1 and `dout` = `mux_addr[3]`.
  - `cfg_q[3]` = 0: all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial configuration data |
| sample | input | DATA_W | Stand-in for the converter output |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| dout_weak | output | 1 | Marks `dout` as a weak idle drive |
| mux_addr | output | 4 | Channel address given to the multiplexer |
| mux_single | output | 1 | Single-ended (1) or differential (0) selection |
| cfg_q | output | 12 | Stored configuration fields |

## Verification
Each serial input passes through two synchronizer stages, then one edge-detect register, then one output register. Every result is therefore due four `clk` cycles after the serial transition that causes it:
- the first `dout` bit after `cs_n` falls;
- each later `dout` bit after its falling edge;
- the `cfg_q` commit after the 13th edge;
- the multiplexer update after the 14th edge;
- the idle level after the 16th edge or after `cs_n` rises.

The bench holds every serial level for eight `clk` cycles. It reads outputs only at the end of such a hold, so each result has settled and the next transition has not yet started. The multiplexer is read once after the 13th edge and once after the 14th edge, which pins its update to the 14th edge.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  // configuration word: one write-enable bit followed by 12 stored bits
  localparam int CFG_W     = 13;
  localparam int ADDR_W    = 4;
  // positions inside the stored 12-bit field
  localparam int F_SEQ     = 11;
  localparam int F_ADDR_LO = 7;
  localparam int F_PM_LO   = 5;
  localparam int F_SHADOW  = 4;
  localparam int F_LINE    = 3;
  localparam int F_RANGE   = 2;
  localparam int F_CODING  = 1;
  localparam int F_SINGLE  = 0;
endpackage

// File: rtl/adc_fe_sync.sv
module adc_fe_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/adc_fe_frame.sv
module adc_fe_frame #(
  parameter int FRAME_LEN = 16,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_s,
  input  logic             sclk_s,
  input  logic             din_s,
  output logic             start_p,
  output logic             end_p,
  output logic             fall_p,
  output logic [IDX_W-1:0] idx,
  output logic             bit_p
);
  logic             cs_d, sclk_d;
  logic [IDX_W-1:0] cnt;
  logic             cs_fall, cs_rise, sck_fall;

  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign sck_fall = sclk_d & ~sclk_s & ~cs_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d    <= 1'b1;
      sclk_d  <= 1'b1;
      cnt     <= '0;
      start_p <= 1'b0;
      end_p   <= 1'b0;
      fall_p  <= 1'b0;
      idx     <= '0;
      bit_p   <= 1'b0;
    end else begin
      cs_d    <= cs_s;
      sclk_d  <= sclk_s;
      start_p <= cs_fall;
      end_p   <= cs_rise;
      fall_p  <= 1'b0;
      if (cs_fall) begin
        cnt <= '0;
      end else if (sck_fall && cnt < IDX_W'(FRAME_LEN)) begin
        cnt    <= cnt + 1'b1;
        fall_p <= 1'b1;
        idx    <= cnt + 1'b1;
        bit_p  <= din_s;
      end
    end
  end

  // R2
  edge_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= IDX_W'(FRAME_LEN));

  // R2
  edge_index_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fall_p |-> (idx != '0) && (idx <= IDX_W'(FRAME_LEN)));
endmodule

// File: rtl/adc_fe_cfg.sv
module adc_fe_cfg
  import adc_fe_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int MUX_EDGE = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              fall_p,
  input  logic [IDX_W-1:0]  idx,
  input  logic              bit_p,
  output logic [CFG_W-2:0]  cfg_q,
  output logic [ADDR_W-1:0] mux_addr,
  output logic              mux_single
);
  logic [CFG_W-2:0] sh;
  logic [CFG_W-1:0] word;

  assign word = {sh, bit_p};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      cfg_q      <= '0;
      mux_addr   <= '0;
      mux_single <= 1'b0;
    end else if (start_p) begin
      sh <= '0;
    end else if (fall_p) begin
      if (idx < IDX_W'(CFG_W)) sh <= {sh[CFG_W-3:0], bit_p};
      if (idx == IDX_W'(CFG_W) && word[CFG_W-1]) cfg_q <= word[CFG_W-2:0];
      if (idx == IDX_W'(MUX_EDGE)) begin
        mux_addr   <= cfg_q[F_ADDR_LO +: ADDR_W];
        mux_single <= cfg_q[F_SINGLE];
      end
    end
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(fall_p && idx == IDX_W'(CFG_W)) |=> $stable(cfg_q));

  // R5
  mux_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(fall_p && idx == IDX_W'(MUX_EDGE)) |=> $stable({mux_addr, mux_single}));
endmodule

// File: rtl/adc_fe_dout.sv
module adc_fe_dout
  import adc_fe_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int IDX_W     = 5,
  parameter int FRAME_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              end_p,
  input  logic              fall_p,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] sample,
  input  logic [ADDR_W-1:0] mux_addr,
  input  logic              coding,
  input  logic              line_mode,
  output logic              dout,
  output logic              dout_oe,
  output logic              dout_weak
);
  localparam int OUT_W = ADDR_W + DATA_W;

  logic [ADDR_W-1:0] res_addr;
  logic [DATA_W-1:0] res_data, coded;
  logic [OUT_W-1:0]  sh;
  logic              drv, last_edge;

  always_comb begin
    coded = sample;
    if (!coding) coded[DATA_W-1] = ~sample[DATA_W-1];
  end

  assign last_edge = fall_p && idx == IDX_W'(FRAME_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_addr  <= '0;
      res_data  <= '0;
      sh        <= '0;
      drv       <= 1'b0;
      dout      <= 1'b0;
      dout_oe   <= 1'b0;
      dout_weak <= 1'b0;
    end else begin
      if (last_edge) begin
        res_addr <= mux_addr;
        res_data <= coded;
      end
      if (start_p) begin
        drv       <= 1'b1;
        sh        <= {res_addr, res_data};
        dout      <= res_addr[ADDR_W-1];
        dout_oe   <= 1'b1;
        dout_weak <= 1'b0;
      end else if (drv && fall_p && idx < IDX_W'(FRAME_LEN)) begin
        sh   <= {sh[OUT_W-2:0], 1'b0};
        dout <= sh[OUT_W-2];
      end else if (!drv || last_edge || end_p) begin
        drv       <= 1'b0;
        dout      <= line_mode & mux_addr[ADDR_W-1];
        dout_oe   <= line_mode;
        dout_weak <= line_mode;
      end
    end
  end

  // R9
  weak_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    dout_weak |-> dout_oe);

  // R9
  weak_level_chk: assert property (@(posedge clk) disable iff (rst)
    dout_weak |-> dout == mux_addr[ADDR_W-1]);

  // R6
  frame_drive_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |=> dout_oe && !dout_weak);
endmodule

// File: rtl/adc_serial_fe.sv
module adc_serial_fe
  import adc_fe_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int MUX_EDGE    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              dout_oe,
  output logic              dout_weak,
  output logic [ADDR_W-1:0] mux_addr,
  output logic              mux_single,
  output logic [CFG_W-2:0]  cfg_q
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);

  logic             cs_s, sclk_s, din_s;
  logic             start_p, end_p, fall_p, bit_p;
  logic [IDX_W-1:0] idx;

  adc_fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sclk, din}),
    .q   ({cs_s, sclk_s, din_s})
  );

  adc_fe_frame #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (cs_s),
    .sclk_s  (sclk_s),
    .din_s   (din_s),
    .start_p (start_p),
    .end_p   (end_p),
    .fall_p  (fall_p),
    .idx     (idx),
    .bit_p   (bit_p)
  );

  adc_fe_cfg #(.IDX_W(IDX_W), .MUX_EDGE(MUX_EDGE)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .start_p    (start_p),
    .fall_p     (fall_p),
    .idx        (idx),
    .bit_p      (bit_p),
    .cfg_q      (cfg_q),
    .mux_addr   (mux_addr),
    .mux_single (mux_single)
  );

  adc_fe_dout #(.DATA_W(DATA_W), .IDX_W(IDX_W), .FRAME_LEN(FRAME_LEN)) u_dout (
    .clk       (clk),
    .rst       (rst),
    .start_p   (start_p),
    .end_p     (end_p),
    .fall_p    (fall_p),
    .idx       (idx),
    .sample    (sample),
    .mux_addr  (mux_addr),
    .coding    (cfg_q[F_CODING]),
    .line_mode (cfg_q[F_LINE]),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .dout_weak (dout_weak)
  );
endmodule

// File: tb/adc_serial_fe_test.sv
module adc_serial_fe_test;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [11:0] sample = '0;
  logic        dout, dout_oe, dout_weak, mux_single;
  logic [3:0]  mux_addr;
  logic [11:0] cfg_q;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [11:0] m_cfg = '0;
  logic [3:0]  m_mux = '0;
  logic        m_single = 1'b0;
  logic [3:0]  m_tag = '0;
  logic [11:0] m_res = '0;

  adc_serial_fe uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din), .sample(sample),
    .dout(dout), .dout_oe(dout_oe), .dout_weak(dout_weak),
    .mux_addr(mux_addr), .mux_single(mux_single), .cfg_q(cfg_q)
  );

  always #10 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    logic lm;
    lm = m_cfg[3];
    check(tag, {29'd0, dout_oe, dout_weak, dout}, {29'd0, lm, lm, lm & m_mux[3]});
  endtask

  task automatic run_frame(input logic [12:0] w, input logic [11:0] s, input int nfall);
    logic [15:0] rx, exp_rx;
    logic        bad_drive;
    rx = '0;
    bad_drive = 1'b0;
    exp_rx = {m_tag, m_res};
    sample = s;
    din = w[12];
    cs_n = 1'b0;
    wait_clk(H);
    for (int k = 0; k < nfall; k++) begin
      rx[15-k] = dout;
      if (!dout_oe || dout_weak) bad_drive = 1'b1;
      sclk = 1'b0;
      wait_clk(H);
      if (k == 12) begin
        if (w[12]) m_cfg = w[11:0];
        check("R2 R3 cfg after 13th edge", {20'd0, cfg_q}, {20'd0, m_cfg});
        check("R5 mux before 14th edge", {27'd0, mux_addr, mux_single}, {27'd0, m_mux, m_single});
      end
      if (k == 13) begin
        m_mux = m_cfg[10:7];
        m_single = m_cfg[0];
        check("R5 mux after 14th edge", {27'd0, mux_addr, mux_single}, {27'd0, m_mux, m_single});
      end
      if (k == 15) begin
        m_tag = m_mux;
        m_res = m_cfg[1] ? s : (s ^ 12'h800);
      end
      sclk = 1'b1;
      din = (k + 1 < 13) ? w[11-k] : 1'b1;  // edges 14..16 see 1s
      wait_clk(H);
    end
    if (nfall == 16) begin
      check("R6 R7 R8 readout word", {16'd0, rx}, {16'd0, exp_rx});
      check("R6 drive during frame", {31'd0, bad_drive}, 32'd0);
      check_idle("R9 idle after 16th edge");
    end
    cs_n = 1'b1;
    din = 1'b0;
    wait_clk(2 * H);
    check_idle("R9 idle with cs high");
    check("R2 R4 cfg after frame", {20'd0, cfg_q}, {20'd0, m_cfg});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    // R1
    check("R1 reset outputs",
          {15'd0, cfg_q, mux_addr, mux_single, dout, dout_oe, dout_weak}, 32'd0);

    // sweep address, coding, line mode and input type
    for (int a = 0; a < 16; a++) begin
      for (int c = 0; c < 2; c++) begin
        for (int wk = 0; wk < 2; wk++) begin
          for (int se = 0; se < 2; se++) begin
            logic [12:0] w;
            logic [11:0] s;
            int n;
            n = a * 8 + c * 4 + wk * 2 + se;
            w = {1'b1, a[0], a[3:0], a[2:1], a[3], wk[0], c[0] ^ se[0], c[0], se[0]};
            s = (n == 0) ? 12'h000 : (n == 1) ? 12'hFFF : (n == 2) ? 12'h800 :
                12'((n * 1237 + 91) % 4096);
            run_frame(w, s, 16);
          end
        end
      end
    end

    // R3: write bit clear leaves configuration alone
    run_frame({1'b0, 12'hFFF}, 12'h3C5, 16);
    run_frame({1'b0, 12'h000}, 12'hA5A, 16);
    run_frame({1'b1, 12'b0_1010_00_0_1_0_1_1}, 12'h7E1, 16);

    // R4: aborted frames at several depths
    run_frame({1'b1, 12'h0F6}, 12'h111, 1);
    run_frame({1'b1, 12'h0F6}, 12'h222, 6);
    run_frame({1'b1, 12'h0F6}, 12'h333, 12);
    // 13 edges commit, 14 move the mux, no capture before the 16th
    run_frame({1'b1, 12'b0_0110_00_0_1_0_0_1}, 12'h444, 13);
    run_frame({1'b1, 12'b0_1100_00_0_1_0_1_0}, 12'h555, 14);
    run_frame({1'b1, 12'b0_1001_00_0_0_0_1_1}, 12'h666, 15);
    run_frame({1'b1, 12'b0_0011_00_0_0_0_0_1}, 12'h0AB, 16);
    run_frame({1'b0, 12'h000}, 12'h000, 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule